// File: doc/BRIEF.md
# Single-Precision NaN Classifier and Quieter

This unit looks at one single-precision floating-point operand per accepted strobe and reports, one clock later, whether it is an ordinary value (including infinity and zero), a quiet NaN or a signaling NaN. In the same registered result it gives a quieted copy of the operand, the default NaN pattern that matches the selected convention, and an invalid-operation flag that is raised whenever a signaling NaN was seen. It sits in front of conversion or propagation logic that needs these answers without re-decoding the operand.

The meaning of the most significant fraction bit is chosen per operand by a runtime polarity input. Under the normal convention a set fraction MSB marks a quiet NaN. Under the inverted convention the roles swap, and a signaling NaN cannot be quieted by flipping one bit, so it is replaced by the default NaN. A build parameter removes signaling NaNs altogether: every NaN is then reported as quiet.

Top module: `nanq_unit`

## Requirements
- R1: An operand is a NaN exactly when its exponent field (bits 30:23) is all ones and its fraction (bits 22:0) is nonzero; any other operand, infinity included, gets class code 0 under both polarities. Class codes: 0 = not a NaN, 1 = quiet NaN, 2 = signaling NaN.
- R2: With `in_inv_pol` = 0, a NaN with fraction bit 22 set is class 1 and a NaN with bit 22 clear is class 2.
- R3: With `in_inv_pol` = 1, a NaN with fraction bit 22 set is class 2 and a NaN with bit 22 clear is class 1.
- R4: When `SNAN_EN` = 0, every NaN is class 1 under either polarity, and `out_invalid` is never set.
- R5: `out_valid` is high in the cycle after each cycle in which `in_valid` is high and low otherwise; the other outputs change only on an accepted input and hold their values in between.
- R6: For a class 2 operand under `in_inv_pol` = 0, `out_quiet` equals the operand with bit 22 set, sign and payload kept; for any operand not of class 2, `out_quiet` equals the operand unchanged.
- R7: For a class 2 operand under `in_inv_pol` = 1, `out_quiet` equals the default NaN 0x7FBFFFFF.
- R8: `out_dnan` is 0x7FC00000 when the accepted operand had `in_inv_pol` = 0 and 0x7FBFFFFF when it had `in_inv_pol` = 1.
- R9: `out_invalid` is 1 exactly when the registered class is 2.
- R10: While `rst` is high and in the first cycle after it, all outputs are 0 unless an input was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 32 | Single-precision operand |
| in_inv_pol | input | 1 | 1 selects inverted quiet-bit convention |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_class | output | 2 | 0 other, 1 quiet NaN, 2 signaling NaN |
| out_quiet | output | 32 | Quieted operand or pass-through |
| out_dnan | output | 32 | Default NaN for the accepted polarity |
| out_invalid | output | 1 | Signaling NaN seen |

## Verification
Classification with its invalid flag and the quieting substitution land in the same registered cycle, and they collide hardest when a signaling NaN arrives under inverted polarity, where the quieted value must become the default NaN while the flag rises. The bench provokes this by sweeping every exponent against fraction patterns with bit 22 set and clear, both signs and both polarities, issued back to back so that polarity flips between neighbouring operands. Each result is judged against a model built from the unsigned-compare and field tests, on a build with signaling NaNs and one without.

// File: rtl/nanq_pkg.sv
package nanq_pkg;

    typedef enum logic [1:0] {
        CLS_OTHER = 2'd0,
        CLS_QNAN  = 2'd1,
        CLS_SNAN  = 2'd2
    } nan_class_e;

    // A signaling NaN is one whose fraction MSB differs from the quiet marker.
    function automatic logic marks_quiet(input logic frac_msb, input logic inv_pol);
        return frac_msb ^ inv_pol;
    endfunction

endpackage

// File: rtl/nanq_classify.sv
module nanq_classify
    import nanq_pkg::*;
#(
    parameter int EXP_W   = 8,
    parameter int FRAC_W  = 23,
    parameter bit SNAN_EN = 1'b1,
    localparam int W      = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] op,
    input  logic         inv_pol,
    output nan_class_e   cls
);
    logic exp_ones;
    logic frac_nz;
    logic is_nan;
    logic is_snan;
    logic is_qnan;

    assign exp_ones = &op[W-2:FRAC_W];
    assign frac_nz  = |op[FRAC_W-1:0];
    assign is_nan   = exp_ones & frac_nz;

    generate
        if (SNAN_EN) begin : g_snan
            assign is_qnan = is_nan &  marks_quiet(op[FRAC_W-1], inv_pol);
            assign is_snan = is_nan & ~marks_quiet(op[FRAC_W-1], inv_pol);
        end else begin : g_nosnan
            assign is_qnan = is_nan;
            assign is_snan = 1'b0;
        end
    endgenerate

    always_comb begin
        if (is_snan)      cls = CLS_SNAN;
        else if (is_qnan) cls = CLS_QNAN;
        else              cls = CLS_OTHER;
    end

endmodule

// File: rtl/nanq_dflt.sv
module nanq_dflt #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic         inv_pol,
    output logic [W-1:0] dnan
);
    logic [FRAC_W-1:0] frac_norm;
    logic [FRAC_W-1:0] frac_inv;

    assign frac_norm = {1'b1, {(FRAC_W-1){1'b0}}};
    assign frac_inv  = {1'b0, {(FRAC_W-1){1'b1}}};
    assign dnan      = {1'b0, {EXP_W{1'b1}}, (inv_pol ? frac_inv : frac_norm)};

endmodule

// File: rtl/nanq_quiet.sv
module nanq_quiet
    import nanq_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] op,
    input  nan_class_e   cls,
    input  logic         inv_pol,
    input  logic [W-1:0] dnan,
    output logic [W-1:0] qval
);
    logic [W-1:0] qbit;

    assign qbit = W'(1) << (FRAC_W - 1);

    always_comb begin
        if (cls != CLS_SNAN) qval = op;
        else if (inv_pol)    qval = dnan;
        else                 qval = op | qbit;
    end

endmodule

// File: rtl/nanq_unit.sv
module nanq_unit
    import nanq_pkg::*;
#(
    parameter int EXP_W   = 8,
    parameter int FRAC_W  = 23,
    parameter bit SNAN_EN = 1'b1,
    localparam int W      = 1 + EXP_W + FRAC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_op,
    input  logic         in_inv_pol,
    output logic         out_valid,
    output logic [1:0]   out_class,
    output logic [W-1:0] out_quiet,
    output logic [W-1:0] out_dnan,
    output logic         out_invalid
);
    nan_class_e   cls_c;
    logic [W-1:0] dnan_c;
    logic [W-1:0] qval_c;
    nan_class_e   cls_q;

    nanq_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .SNAN_EN(SNAN_EN)) u_classify (
        .op      (in_op),
        .inv_pol (in_inv_pol),
        .cls     (cls_c)
    );

    nanq_dflt #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dflt (
        .inv_pol (in_inv_pol),
        .dnan    (dnan_c)
    );

    nanq_quiet #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_quiet (
        .op      (in_op),
        .cls     (cls_c),
        .inv_pol (in_inv_pol),
        .dnan    (dnan_c),
        .qval    (qval_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            cls_q       <= CLS_OTHER;
            out_quiet   <= '0;
            out_dnan    <= '0;
            out_invalid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                cls_q       <= cls_c;
                out_quiet   <= qval_c;
                out_dnan    <= dnan_c;
                out_invalid <= (cls_c == CLS_SNAN);
            end
        end
    end

    assign out_class = cls_q;

    // R5: a result strobe only follows an accepted operand
    a_r5_valid_follows: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R9: flag and class agree at all times
    a_r9_invalid_class: assert property (@(posedge clk) disable iff (rst)
        out_invalid == (out_class == 2'd2));

    // R6: normal-polarity quieting keeps the operand and sets the quiet bit
    a_r6_quiet_bit: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_class == 2'd2 && !$past(in_inv_pol))
        |-> (out_quiet == ($past(in_op) | (W'(1) << (FRAC_W - 1)))));

    // R7: inverted-polarity quieting yields the default NaN
    a_r7_quiet_dflt: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_class == 2'd2 && $past(in_inv_pol))
        |-> (out_quiet == out_dnan));

    // R6: non-signaling operands pass through
    a_r6_pass: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_class != 2'd2) |-> (out_quiet == $past(in_op)));

    generate
        if (!SNAN_EN) begin : g_chk_nosnan
            // R4: no signaling class is ever reported
            a_r4_no_snan: assert property (@(posedge clk) disable iff (rst)
                out_valid |-> (out_class != 2'd2));
        end
    endgenerate

endmodule

// File: tb/nanq_unit_bench.sv
module nanq_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] in_op;
    logic        in_inv_pol;

    logic        v1, v0;
    logic [1:0]  c1, c0;
    logic [31:0] q1, q0, d1, d0;
    logic        i1, i0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    nanq_unit u_nanq_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_inv_pol(in_inv_pol),
        .out_valid(v1), .out_class(c1), .out_quiet(q1), .out_dnan(d1), .out_invalid(i1)
    );

    nanq_unit #(.SNAN_EN(1'b0)) u_nanq_unit_nosn (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_inv_pol(in_inv_pol),
        .out_valid(v0), .out_class(c0), .out_quiet(q0), .out_dnan(d0), .out_invalid(i0)
    );

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s op=%h pol=%0b actual=%h expected=%h", tag, in_op, in_inv_pol, act, exp);
        end
    endtask

    // Model from the stated tests: unsigned compare and exponent/fraction field test.
    task automatic model(input logic [31:0] v, input bit pol, input bit sen,
                         output logic [1:0] c, output logic [31:0] q,
                         output logic [31:0] d, output bit inv);
        bit cmp_t, fld_t, isq, iss;
        logic [31:0] sh;
        sh    = v << 1;
        cmp_t = (sh >= 32'hFF800000);
        fld_t = (v[30:22] == 9'h1FE) && (v[21:0] != 22'd0);
        d     = pol ? 32'h7FBFFFFF : 32'h7FC00000;
        isq   = pol ? fld_t : cmp_t;
        iss   = pol ? cmp_t : fld_t;
        if (!sen) begin
            isq = isq | iss;
            iss = 1'b0;
        end
        c   = iss ? 2'd2 : (isq ? 2'd1 : 2'd0);
        inv = iss;
        q   = !iss ? v : (pol ? d : (v | 32'h00400000));
    endtask

    // Drive one operand, then check both builds one cycle later.
    task automatic apply(input logic [31:0] v, input bit pol, input string ctag);
        logic [1:0] ec; logic [31:0] eq, ed; bit ei;
        in_valid   = 1'b1;
        in_op      = v;
        in_inv_pol = pol;
        @(negedge clk);
        in_valid = 1'b0;
        model(v, pol, 1'b1, ec, eq, ed, ei);
        cmp({"R5 valid ", ctag}, {31'd0, v1}, 32'd1);
        cmp(ctag, {30'd0, c1}, {30'd0, ec});
        cmp(pol ? "R7 quiet" : "R6 quiet", q1, eq);
        cmp("R8 dnan", d1, ed);
        cmp("R9 invalid", {31'd0, i1}, {31'd0, ei});
        model(v, pol, 1'b0, ec, eq, ed, ei);
        cmp("R4 class", {30'd0, c0}, {30'd0, ec});
        cmp("R4 invalid", {31'd0, i0}, {31'd0, ei});
        cmp("R4 quiet", q0, eq);
    endtask

    function automatic string tag_of(input logic [31:0] v, input bit pol);
        if (!((v[30:23] == 8'hFF) && (v[22:0] != 23'd0))) return "R1 class";
        return pol ? "R3 class" : "R2 class";
    endfunction

    initial begin : watchdog
        while (cycles < 190000) begin
            @(posedge clk);
            cycles++;
        end
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, 190000);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : stim
        logic [31:0] fr [0:8];
        logic [31:0] held;
        rst = 1'b1; in_valid = 1'b0; in_op = 32'h7F800001; in_inv_pol = 1'b0;
        repeat (3) @(negedge clk);
        // R10: reset state
        cmp("R10 valid", {31'd0, v1}, 32'd0);
        cmp("R10 class", {30'd0, c1}, 32'd0);
        cmp("R10 quiet", q1, 32'd0);
        cmp("R10 dnan", d1, 32'd0);
        cmp("R10 invalid", {31'd0, i1}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        cmp("R10 after", {31'd0, v1} | {31'd0, i1} | q1 | d1, 32'd0);

        // Directed corners
        apply(32'h7F800000, 1'b0, "R1 inf");
        apply(32'hFF800000, 1'b1, "R1 inf");
        apply(32'h7FC00000, 1'b0, "R2 qnan");
        apply(32'hFF800001, 1'b0, "R2 snan");
        apply(32'h7FC00000, 1'b1, "R3 snan");
        apply(32'h7FBFFFFF, 1'b1, "R3 qnan");
        apply(32'h80A12345, 1'b1, "R1 normal");

        // R5: hold with no strobe
        apply(32'hFFA5A5A5, 1'b0, "R6 snan");
        held = q1;
        in_op = 32'h00000000; in_inv_pol = 1'b1;
        @(negedge clk);
        cmp("R5 no valid", {31'd0, v1}, 32'd0);
        cmp("R5 hold quiet", q1, held);
        cmp("R5 hold dnan", d1, 32'h7FC00000);
        cmp("R5 hold class", {30'd0, c1}, 32'd2);

        // Near-exhaustive sweep: every exponent against fraction patterns, back to back
        fr[0] = 32'h000000; fr[1] = 32'h000001; fr[2] = 32'h400000;
        fr[3] = 32'h400001; fr[4] = 32'h7FFFFF; fr[5] = 32'h3FFFFF;
        fr[6] = 32'h200000; fr[7] = 32'h155555; fr[8] = 32'h6AAAAA;
        for (int e = 0; e < 256; e++) begin
            for (int f = 0; f < 9 + 23; f++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int p = 0; p < 2; p++) begin
                        logic [22:0] fv;
                        logic [31:0] v;
                        fv = (f < 9) ? fr[f][22:0] : (23'd1 << (f - 9));
                        v  = {s[0], e[7:0], fv};
                        apply(v, p[0], tag_of(v, p[0]));
                    end
                end
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule